// File: doc/BRIEF.md
# Reservation Station with Result-Bus Snooping

This block holds a small pool of waiting operations for a speculative out-of-order core. At issue, an operation enters a free slot only when the core also reports a free reorder-buffer slot. Each of the two source operands comes in either as a value or as the reorder-buffer number of the operation that will produce it. Every operation is labelled with its own reorder-buffer number, so speculative results pass between operations without ever touching the register file.

While an operand is pending, its slot compares every valid broadcast on the result buses with the tag it waits for, and copies the value when they match. A slot whose operands are all present competes for the single dispatch port. The oldest competing slot wins, and it sends its opcode, operands and destination tag to the functional unit. For a store, the slot computes only the address, so it needs only the base operand and sends the offset as its second operand. A flush empties the whole pool.

Each slot runs a three-state machine. The states are `ST_FREE` (empty), `ST_WAIT` (holds an operation with at least one missing operand) and `ST_READY` (holds an operation with every needed operand). The transitions are:
- *alloc*: `ST_FREE` to `ST_WAIT`, or straight to `ST_READY` when every needed operand is already known at issue.
- *capture*: `ST_WAIT` to `ST_READY` when the last missing operand is seen on a bus.
- *grant*: `ST_READY` to `ST_FREE` on dispatch.
- *flush*: any state to `ST_FREE`.

Top module: `rsv_station`

## Requirements
- R1: `iss_ready` is 1 only when at least one slot is free, `rob_has_slot` is 1 and `flush` is 0. An issue with `iss_ready` at 0 is not taken.
- R2: A source with its ready flag at 1 is taken as the supplied value. A source with the flag at 0 is recorded as waiting on the supplied tag.
- R3: A waiting operand takes the data of any bus `k` with `cdb_valid[k]` at 1 and `cdb_tag[k]` equal to its tag. A broadcast with any other tag leaves the operand waiting.
- R4: A broadcast in the same cycle as the issue that names the same tag is captured at issue. The operation can then dispatch in the next cycle.
- R5: An operation dispatches only when every operand it needs is present. A waiting operation does not raise `disp_valid`.
- R6: When several slots are ready, the one allocated earliest dispatches first, whatever its slot index.
- R7: At most one operation dispatches per cycle. None dispatches while `fu_busy` is 1, and a held operation stays queued.
- R8: `disp_dest` carries the reorder-buffer number given at issue in `iss_dest`.
- R9: A store (`iss_store`=1) needs only its base operand. It dispatches with `disp_a` equal to the base and `disp_b` equal to `iss_offset`, even if its second operand never arrives.
- R10: While `flush` is 1, `disp_valid` and `iss_ready` are 0. In the next cycle every slot is free.
- R11: After reset every slot is free and `disp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties every slot |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode |
| iss_store | input | 1 | Operation is a store address calculation |
| iss_a_rdy | input | 1 | Operand A given as a value |
| iss_a_val | input | DATA_W | Operand A value |
| iss_a_tag | input | TAG_W | Operand A producer tag |
| iss_b_rdy | input | 1 | Operand B given as a value |
| iss_b_val | input | DATA_W | Operand B value |
| iss_b_tag | input | TAG_W | Operand B producer tag |
| iss_offset | input | DATA_W | Store address offset |
| iss_dest | input | TAG_W | Reorder-buffer number of this operation |
| rob_has_slot | input | 1 | Reorder buffer can accept an entry |
| iss_ready | output | 1 | Issue is accepted this cycle |
| cdb_valid | input | CDB_N | Per-bus broadcast valid |
| cdb_tag | input | CDB_N*TAG_W | Per-bus broadcast tag, bus k at bits k*TAG_W |
| cdb_data | input | CDB_N*DATA_W | Per-bus broadcast data, bus k at bits k*DATA_W |
| fu_busy | input | 1 | Functional unit cannot accept |
| disp_valid | output | 1 | Dispatch this cycle |
| disp_op | output | OP_W | Dispatched opcode |
| disp_store | output | 1 | Dispatched operation is a store |
| disp_a | output | DATA_W | First operand or store base |
| disp_b | output | DATA_W | Second operand or store offset |
| disp_dest | output | TAG_W | Destination reorder-buffer number |

## Verification
The bench builds the station with four slots, two result buses, 4-bit tags and 16-bit data. Four slots are few enough that a handful of issues fills the pool and reaches the stall on a full station. Two buses let a match arrive on the second bus while the first carries a different tag. With four slots, one dispatch followed by a refill of a low index makes allocation age differ from slot order, so the oldest-first rule is observable.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } slot_state_t;

endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] busy,
    output logic [N-1:0] free_oh,
    output logic         any_free
);

    always_comb begin
        free_oh  = '0;
        any_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!busy[i] && !any_free) begin
                free_oh[i] = 1'b1;
                any_free   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_oh,
    input  logic [N-1:0] busy,
    input  logic [N-1:0] ready,
    input  logic         enable,
    output logic [N-1:0] grant_oh
);

    // elder_q[i][j] == 1 : slot i was allocated before slot j
    logic [N-1:0] elder_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) elder_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (alloc_oh[i]) begin
                    elder_q[i] <= '0;
                end else begin
                    for (int j = 0; j < N; j++) begin
                        if (alloc_oh[j] && busy[i]) elder_q[i][j] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            grant_oh[i] = enable && ready[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && ready[j] && elder_q[j][i]) grant_oh[i] = 1'b0;
            end
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh)); // R7

endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 4,
    parameter int CDB_N  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    alloc,
    input  logic [OP_W-1:0]         in_op,
    input  logic                    in_store,
    input  logic                    in_a_rdy,
    input  logic [DATA_W-1:0]       in_a_val,
    input  logic [TAG_W-1:0]        in_a_tag,
    input  logic                    in_b_rdy,
    input  logic [DATA_W-1:0]       in_b_val,
    input  logic [TAG_W-1:0]        in_b_tag,
    input  logic [DATA_W-1:0]       in_off,
    input  logic [TAG_W-1:0]        in_dest,
    input  logic [CDB_N-1:0]        cdb_valid,
    input  logic [CDB_N*TAG_W-1:0]  cdb_tag,
    input  logic [CDB_N*DATA_W-1:0] cdb_data,
    input  logic                    grant,
    output logic                    busy,
    output logic                    ready,
    output logic [OP_W-1:0]         out_op,
    output logic                    out_store,
    output logic [DATA_W-1:0]       out_a,
    output logic [DATA_W-1:0]       out_b,
    output logic [TAG_W-1:0]        out_dest
);

    slot_state_t       state_q, state_d;
    logic [OP_W-1:0]   op_q;
    logic              store_q;
    logic              a_rdy_q, b_rdy_q;
    logic [DATA_W-1:0] a_val_q, b_val_q, off_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q, dest_q;

    logic [TAG_W-1:0]  a_look, b_look;
    logic              a_hit, b_hit;
    logic [DATA_W-1:0] a_hit_val, b_hit_val;
    logic              a_have, b_have, need_b;

    // snoop every bus against the tag in question (incoming tag during alloc)
    always_comb begin
        a_look    = alloc ? in_a_tag : a_tag_q;
        b_look    = alloc ? in_b_tag : b_tag_q;
        a_hit     = 1'b0;
        b_hit     = 1'b0;
        a_hit_val = '0;
        b_hit_val = '0;
        for (int k = 0; k < CDB_N; k++) begin
            if (cdb_valid[k] && cdb_tag[k*TAG_W +: TAG_W] == a_look) begin
                a_hit     = 1'b1;
                a_hit_val = cdb_data[k*DATA_W +: DATA_W];
            end
            if (cdb_valid[k] && cdb_tag[k*TAG_W +: TAG_W] == b_look) begin
                b_hit     = 1'b1;
                b_hit_val = cdb_data[k*DATA_W +: DATA_W];
            end
        end
        a_have = alloc ? (in_a_rdy || a_hit) : (a_rdy_q || a_hit);
        b_have = alloc ? (in_b_rdy || b_hit) : (b_rdy_q || b_hit);
        need_b = alloc ? !in_store : !store_q;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:  if (alloc) state_d = (a_have && (b_have || !need_b)) ? ST_READY : ST_WAIT;
            ST_WAIT:  if (a_have && (b_have || !need_b)) state_d = ST_READY;
            ST_READY: if (grant) state_d = ST_FREE;
            default:  state_d = ST_FREE;
        endcase
        if (flush) state_d = ST_FREE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // payload and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            store_q <= 1'b0;
            a_rdy_q <= 1'b1;
            b_rdy_q <= 1'b1;
            a_val_q <= '0;
            b_val_q <= '0;
            a_tag_q <= '0;
            b_tag_q <= '0;
            off_q   <= '0;
            dest_q  <= '0;
        end else if (alloc) begin
            op_q    <= in_op;
            store_q <= in_store;
            a_rdy_q <= in_a_rdy || a_hit;
            b_rdy_q <= in_b_rdy || b_hit;
            a_val_q <= in_a_rdy ? in_a_val : a_hit_val;
            b_val_q <= in_b_rdy ? in_b_val : b_hit_val;
            a_tag_q <= in_a_tag;
            b_tag_q <= in_b_tag;
            off_q   <= in_off;
            dest_q  <= in_dest;
        end else if (state_q == ST_WAIT) begin
            if (!a_rdy_q && a_hit) begin
                a_rdy_q <= 1'b1;
                a_val_q <= a_hit_val;
            end
            if (!b_rdy_q && b_hit) begin
                b_rdy_q <= 1'b1;
                b_val_q <= b_hit_val;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_FREE);
        ready     = (state_q == ST_READY);
        out_op    = op_q;
        out_store = store_q;
        out_a     = a_val_q;
        out_b     = store_q ? off_q : b_val_q;
        out_dest  = dest_q;
    end

    AST_READY_HAS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |-> (a_rdy_q && (b_rdy_q || store_q))); // R5
    AST_GRANT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (state_q == ST_READY)); // R5
    AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (state_q == ST_FREE)); // R1

endmodule

// File: rtl/rsv_station.sv
module rsv_station #(
    parameter int NUM_SLOTS = 4,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 4,
    parameter int OP_W      = 4,
    parameter int CDB_N     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    iss_valid,
    input  logic [OP_W-1:0]         iss_op,
    input  logic                    iss_store,
    input  logic                    iss_a_rdy,
    input  logic [DATA_W-1:0]       iss_a_val,
    input  logic [TAG_W-1:0]        iss_a_tag,
    input  logic                    iss_b_rdy,
    input  logic [DATA_W-1:0]       iss_b_val,
    input  logic [TAG_W-1:0]        iss_b_tag,
    input  logic [DATA_W-1:0]       iss_offset,
    input  logic [TAG_W-1:0]        iss_dest,
    input  logic                    rob_has_slot,
    output logic                    iss_ready,
    input  logic [CDB_N-1:0]        cdb_valid,
    input  logic [CDB_N*TAG_W-1:0]  cdb_tag,
    input  logic [CDB_N*DATA_W-1:0] cdb_data,
    input  logic                    fu_busy,
    output logic                    disp_valid,
    output logic [OP_W-1:0]         disp_op,
    output logic                    disp_store,
    output logic [DATA_W-1:0]       disp_a,
    output logic [DATA_W-1:0]       disp_b,
    output logic [TAG_W-1:0]        disp_dest
);

    localparam int N = NUM_SLOTS;

    logic [N-1:0]      busy_vec, ready_vec, free_oh, alloc_oh, grant_oh;
    logic              any_free, take;
    logic [OP_W-1:0]   e_op   [N];
    logic              e_st   [N];
    logic [DATA_W-1:0] e_a    [N];
    logic [DATA_W-1:0] e_b    [N];
    logic [TAG_W-1:0]  e_dest [N];

    rs_free_pick #(.N(N)) u_free (
        .busy     (busy_vec),
        .free_oh  (free_oh),
        .any_free (any_free)
    );

    assign iss_ready = any_free && rob_has_slot && !flush;
    assign take      = iss_valid && iss_ready;
    assign alloc_oh  = take ? free_oh : '0;

    rs_age_pick #(.N(N)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_oh (alloc_oh),
        .busy     (busy_vec),
        .ready    (ready_vec),
        .enable   (!fu_busy && !flush),
        .grant_oh (grant_oh)
    );

    for (genvar g = 0; g < N; g++) begin : g_slot
        rs_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .OP_W   (OP_W),
            .CDB_N  (CDB_N)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .alloc     (alloc_oh[g]),
            .in_op     (iss_op),
            .in_store  (iss_store),
            .in_a_rdy  (iss_a_rdy),
            .in_a_val  (iss_a_val),
            .in_a_tag  (iss_a_tag),
            .in_b_rdy  (iss_b_rdy),
            .in_b_val  (iss_b_val),
            .in_b_tag  (iss_b_tag),
            .in_off    (iss_offset),
            .in_dest   (iss_dest),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_data  (cdb_data),
            .grant     (grant_oh[g]),
            .busy      (busy_vec[g]),
            .ready     (ready_vec[g]),
            .out_op    (e_op[g]),
            .out_store (e_st[g]),
            .out_a     (e_a[g]),
            .out_b     (e_b[g]),
            .out_dest  (e_dest[g])
        );
    end

    always_comb begin
        disp_valid = |grant_oh;
        disp_op    = '0;
        disp_store = 1'b0;
        disp_a     = '0;
        disp_b     = '0;
        disp_dest  = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_oh[i]) begin
                disp_op    = disp_op    | e_op[i];
                disp_store = disp_store | e_st[i];
                disp_a     = disp_a     | e_a[i];
                disp_b     = disp_b     | e_b[i];
                disp_dest  = disp_dest  | e_dest[i];
            end
        end
    end

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy_vec) |-> !iss_ready); // R1
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fu_busy |-> !disp_valid); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_vec == '0)); // R10
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!disp_valid && !iss_ready)); // R10

endmodule

// File: tb/rsv_station_bench.sv
module rsv_station_bench;

    localparam int NS = 4;
    localparam int DW = 16;
    localparam int TW = 4;
    localparam int OW = 4;
    localparam int CN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic iss_valid = 1'b0;
    logic [OW-1:0] iss_op = '0;
    logic iss_store = 1'b0;
    logic iss_a_rdy = 1'b0, iss_b_rdy = 1'b0;
    logic [DW-1:0] iss_a_val = '0, iss_b_val = '0, iss_offset = '0;
    logic [TW-1:0] iss_a_tag = '0, iss_b_tag = '0, iss_dest = '0;
    logic rob_has_slot = 1'b1;
    logic iss_ready;
    logic [CN-1:0] cdb_valid = '0;
    logic [CN*TW-1:0] cdb_tag = '0;
    logic [CN*DW-1:0] cdb_data = '0;
    logic fu_busy = 1'b0;
    logic disp_valid, disp_store;
    logic [OW-1:0] disp_op;
    logic [DW-1:0] disp_a, disp_b;
    logic [TW-1:0] disp_dest;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rsv_station #(
        .NUM_SLOTS(NS), .DATA_W(DW), .TAG_W(TW), .OP_W(OW), .CDB_N(CN)
    ) u_rsv_station (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_store(iss_store),
        .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
        .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
        .iss_offset(iss_offset), .iss_dest(iss_dest),
        .rob_has_slot(rob_has_slot), .iss_ready(iss_ready),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .fu_busy(fu_busy), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_store(disp_store), .disp_a(disp_a), .disp_b(disp_b),
        .disp_dest(disp_dest)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // advance to the next falling edge and drop one-cycle pulses
    task automatic next_cycle();
        @(negedge clk);
        iss_valid = 1'b0;
        cdb_valid = '0;
        flush     = 1'b0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic drive_issue(input logic st, input logic ar, input logic [DW-1:0] av,
                               input logic [TW-1:0] at, input logic br,
                               input logic [DW-1:0] bv, input logic [TW-1:0] bt,
                               input logic [DW-1:0] off, input logic [TW-1:0] dst);
        iss_valid  = 1'b1;
        iss_op     = dst;
        iss_store  = st;
        iss_a_rdy  = ar; iss_a_val = av; iss_a_tag = at;
        iss_b_rdy  = br; iss_b_val = bv; iss_b_tag = bt;
        iss_offset = off;
        iss_dest   = dst;
    endtask

    task automatic drive_bus(input int k, input logic [TW-1:0] t, input logic [DW-1:0] d);
        cdb_valid[k]          = 1'b1;
        cdb_tag[k*TW +: TW]   = t;
        cdb_data[k*DW +: DW]  = d;
    endtask

    task automatic t_reset();
        next_cycle(); settle();
        check("R11 disp_valid after reset", disp_valid, 0);
        check("R1 iss_ready empty station", iss_ready, 1);
        rob_has_slot = 1'b0; settle();
        check("R1 iss_ready without rob slot", iss_ready, 0);
        rob_has_slot = 1'b1;
    endtask

    task automatic t_ready_operands();
        next_cycle();
        drive_issue(0, 1, 16'h0010, 0, 1, 16'h0020, 0, 0, 4'd3); settle();
        check("R1 iss_ready with space", iss_ready, 1);
        next_cycle(); settle();
        check("R5 ready op dispatches", disp_valid, 1);
        check("R2 operand a value", disp_a, 16'h0010);
        check("R2 operand b value", disp_b, 16'h0020);
        check("R8 dest tag", disp_dest, 3);
        next_cycle(); settle();
        check("R7 slot freed after dispatch", disp_valid, 0);
    endtask

    task automatic t_snoop();
        next_cycle();
        drive_issue(0, 0, 0, 4'd5, 1, 16'h0007, 0, 0, 4'd1);
        next_cycle(); settle();
        check("R5 waiting op held", disp_valid, 0);
        drive_bus(0, 4'd6, 16'h1234);
        next_cycle(); settle();
        check("R3 other tag ignored", disp_valid, 0);
        drive_bus(1, 4'd5, 16'h0099);
        drive_bus(0, 4'd9, 16'h0AAA);
        settle();
        check("R5 no dispatch in capture cycle", disp_valid, 0);
        next_cycle(); settle();
        check("R3 captured op dispatches", disp_valid, 1);
        check("R3 captured value from bus 1", disp_a, 16'h0099);
        check("R2 ready b kept", disp_b, 16'h0007);
        check("R8 dest tag", disp_dest, 1);
        next_cycle();
    endtask

    task automatic t_issue_bypass();
        next_cycle();
        drive_issue(0, 0, 0, 4'd2, 1, 16'h0003, 0, 0, 4'd7);
        drive_bus(0, 4'd2, 16'h0055);
        next_cycle(); settle();
        check("R4 same-cycle capture dispatches", disp_valid, 1);
        check("R4 same-cycle value", disp_a, 16'h0055);
        next_cycle();
    endtask

    task automatic t_age_order();
        next_cycle(); fu_busy = 1'b1;
        drive_issue(0, 0, 0, 4'd7, 1, 16'h0001, 0, 0, 4'd4);   // A, waits, slot0
        next_cycle();
        drive_issue(0, 1, 16'h0002, 0, 1, 16'h0002, 0, 0, 4'd5); // B, slot1
        next_cycle();
        drive_issue(0, 1, 16'h0003, 0, 1, 16'h0003, 0, 0, 4'd6); // C, slot2
        next_cycle(); fu_busy = 1'b0; settle();
        check("R6 oldest ready first", disp_dest, 5);
        next_cycle(); fu_busy = 1'b1;
        drive_issue(0, 1, 16'h0004, 0, 1, 16'h0004, 0, 0, 4'd2);   // D, refills slot1
        settle();
        check("R7 held while fu busy", disp_valid, 0);
        next_cycle();
        drive_bus(0, 4'd7, 16'h0011);
        next_cycle(); fu_busy = 1'b0; settle();
        check("R6 oldest A first", disp_dest, 4);
        check("R3 A captured value", disp_a, 16'h0011);
        next_cycle(); settle();
        check("R6 then C", disp_dest, 6);
        next_cycle(); settle();
        check("R6 then D", disp_dest, 2);
        next_cycle(); settle();
        check("R7 one per cycle drains", disp_valid, 0);
    endtask

    task automatic t_store();
        next_cycle();
        drive_issue(1, 1, 16'h0100, 0, 0, 0, 4'd3, 16'h0008, 4'd9);
        next_cycle(); settle();
        check("R9 store dispatches on base", disp_valid, 1);
        check("R9 store flag", disp_store, 1);
        check("R9 store base", disp_a, 16'h0100);
        check("R9 store offset", disp_b, 16'h0008);
        next_cycle();
    endtask

    task automatic t_full_and_flush();
        next_cycle(); fu_busy = 1'b1;
        for (int i = 0; i < NS; i++) begin
            drive_issue(0, 1, 16'(i), 0, 1, 16'(i), 0, 0, 4'(i + 8));
            settle();
            check("R1 accepting while space", iss_ready, 1);
            next_cycle();
        end
        drive_issue(0, 1, 16'hFFFF, 0, 1, 0, 0, 0, 4'd15);
        settle();
        check("R1 stall when full", iss_ready, 0);
        next_cycle();
        fu_busy = 1'b0; flush = 1'b1; settle();
        check("R10 no dispatch during flush", disp_valid, 0);
        check("R10 no issue during flush", iss_ready, 0);
        next_cycle(); settle();
        check("R10 empty after flush", disp_valid, 0);
        check("R10 space after flush", iss_ready, 1);
        next_cycle(); settle();
        check("R10 stalled issue not taken", disp_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_ready_operands();
        t_snoop();
        t_issue_bypass();
        t_age_order();
        t_store();
        t_full_and_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule